// File: doc/BRIEF.md
# Burst SPI Sensor Collector

This block is the host side of a serial link to an inertial sensor. It acts as an SPI master in mode 3: the clock idles high, the outgoing bit changes on the falling edge, the incoming bit is sampled on the rising edge, and words are 16 bits long, most significant bit first. When the sensor raises its data-ready line, the collector sends the burst command word 0x3E00 and keeps chip select low. It then clocks in a fixed number of response words and presents each one on a valid/index/data output, so downstream logic can store it or act on it.

It also performs single register reads. The first frame carries a clear top bit and the register address. Chip select is then released briefly, and a second frame collects the register contents. The SCLK half-period is set in system clock cycles by an input. For bursts, a floor parameter raises that value so the serial clock stays inside the slower burst-mode limit.

Control is a single state machine with six states:

- **IDLE**: chip select high, clock high. Leaves for LEAD on a burst or read start.
- **LEAD**: chip select low, lasting one half-period. Goes to LOW.
- **LOW**: clock low for one half-period. Goes to HIGH, sampling MISO at the rising edge.
- **HIGH**: clock high for one half-period. After bit 16 it ends the frame; otherwise it returns to LOW and shifts MOSI.
  - If the burst continues, it goes to GAP.
  - If a read continues, it goes to CSOFF.
  - After the last frame, it goes to IDLE.
- **GAP**: chip select held low, clock high for two half-periods. Goes to LOW.
- **CSOFF**: chip select high for two half-periods. Goes to LEAD.

Top module: `burst_spi_collector`

## Requirements
- R1: After reset cs_n_o and sclk_o are 1, and busy_o, word_valid_o, rd_valid_o and overrun_o are 0.
- R2: A rising edge on drdy_i while idle starts a burst whose first frame sends 0x3E00 MSB first in mode 3 (SCLK idles high, MOSI changes on falling edges, MISO sampled on rising edges); SCLK is high whenever chip select is released.
- R3: After the command frame the burst runs N_WORDS further 16-bit frames sending 0x0000 with chip select held low; each received word is presented for one cycle on word_valid_o with word_idx_o counting 0 to N_WORDS-1 in order, and the response to the command frame is discarded.
- R4: During a burst every SCLK half-period lasts max(half_div_i, MIN_BURST_HALF) clock cycles, with the value latched at the start.
- R5: During a register read every SCLK half-period lasts max(half_div_i, 1) clock cycles.
- R6: Between consecutive burst frames SCLK stays high for one extra full SCLK period, so three half-periods separate the last rising edge of one frame from the first falling edge of the next.
- R7: Chip select falls one half-period before the first falling SCLK edge and rises one half-period after the last rising edge.
- R8: A pulse on rd_req_i while idle sends {0, rd_addr_i[6:0], 8'h00}, releases chip select for two half-periods, then sends 0x0000; the word received in that second frame appears once on rd_valid_o/rd_data_o and word_valid_o stays low.
- R9: A drdy_i rising edge while a transfer is in progress neither starts nor alters a transfer and sets overrun_o, which stays 1 until reset.
- R10: If drdy_i rises in the same idle cycle as rd_req_i, the burst is run and the read is dropped; rd_req_i while busy is ignored.
- R11: busy_o is 1 whenever chip select is asserted and returns to 0 when the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_i | input | 1 | Sensor data-ready, synchronous; rising edge starts a burst |
| rd_req_i | input | 1 | Start a single register read |
| rd_addr_i | input | 7 | Register address for a read |
| half_div_i | input | DIV_W | Requested SCLK half-period in clock cycles |
| miso_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock, idle high |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the sensor |
| busy_o | output | 1 | Transfer in progress |
| word_valid_o | output | 1 | One-cycle strobe for a burst word |
| word_idx_o | output | $clog2(N_WORDS) | Position of the word within the burst |
| word_data_o | output | 16 | Burst word |
| rd_valid_o | output | 1 | One-cycle strobe for a register read result |
| rd_data_o | output | 16 | Register read result |
| overrun_o | output | 1 | Sticky: data-ready arrived while busy |

## Verification
The assertions check, on every cycle, the properties that need no history beyond a few cycles:
- SCLK is high whenever chip select is released.
- busy_o covers every asserted chip select.
- Each burst-mode half-period reaches the floor length.
- Word strobes last one cycle with an index in range.
- The overrun flag never clears.

The bench's scenarios show the rest, using a behavioural sensor model that returns known words:
- the bit order and content of the frames;
- the measured lead, trail, gap and half-period lengths;
- the word order and the dropped command response;
- the read path, the priority rule, and the dropping of data-ready edges during a transfer.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_CSOFF
    } bsc_state_e;

    localparam int          FRAME_BITS = 16;
    localparam logic [15:0] BURST_CMD  = 16'h3E00;
endpackage

// File: rtl/bsc_halfclk.sv
module bsc_halfclk #(
    parameter int DIV_W          = 8,
    parameter int MIN_BURST_HALF = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             burst_sel,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam int FLOOR_W = $clog2(MIN_BURST_HALF + 1);
    localparam int CNT_W   = (DIV_W > FLOOR_W) ? DIV_W : FLOOR_W;

    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] req_w;
    logic             burst_q;

    always_comb begin
        req_w = CNT_W'(half_div);
        if (burst_sel && (req_w < CNT_W'(MIN_BURST_HALF))) begin
            req_w = CNT_W'(MIN_BURST_HALF);
        end
        if (req_w == '0) begin
            req_w = CNT_W'(1);
        end
    end

    assign tick = run && (cnt_q == (half_q - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= CNT_W'(1);
            cnt_q   <= '0;
            burst_q <= 1'b0;
        end else begin
            if (load) begin
                half_q  <= req_w;
                burst_q <= burst_sel;
            end
            if (!run || tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_BURST_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && burst_q) |-> (cnt_q >= CNT_W'(MIN_BURST_HALF - 1))) // R4
        else $error("burst half-period below floor");
endmodule

// File: rtl/bsc_shreg.sv
module bsc_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_word;
            end else if (shift) begin
                tx_q <= {tx_q[W-2:0], 1'b0};
            end
            if (sample) begin
                rx_q <= {rx_q[W-2:0], miso};
            end
        end
    end

    assign mosi    = tx_q[W-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/bsc_fsm.sv
module bsc_fsm
    import bsc_pkg::*;
#(
    parameter int N_WORDS = 12,
    parameter int ADDR_W  = 7,
    parameter int IDX_W   = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              tick_i,
    input  logic [15:0]       rx_word_i,
    output logic              tmr_load_o,
    output logic              tmr_burst_o,
    output logic              tmr_run_o,
    output logic              sh_load_o,
    output logic [15:0]       sh_word_o,
    output logic              sh_shift_o,
    output logic              sh_sample_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic              word_valid_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic [15:0]       word_data_o,
    output logic              rd_valid_o,
    output logic [15:0]       rd_data_o,
    output logic              overrun_o
);
    localparam int FRM_W = $clog2(N_WORDS + 1);
    localparam int PAD_W = FRAME_BITS - 1 - ADDR_W;

    bsc_state_e       state_q, state_d;
    logic             burst_q;
    logic [FRM_W-1:0] frame_q;
    logic [4:0]       bit_q;
    logic             half2_q;
    logic             drdy_q;
    logic             overrun_q;
    logic             wv_q, rv_q;
    logic [IDX_W-1:0] widx_q;
    logic [15:0]      wdata_q, rdata_q;

    logic drdy_edge, start_burst, start_read;
    logic frame_end, last_frame;

    assign drdy_edge   = drdy_i && !drdy_q;
    assign start_burst = (state_q == ST_IDLE) && drdy_edge;
    assign start_read  = (state_q == ST_IDLE) && !drdy_edge && rd_req_i;
    assign frame_end   = (state_q == ST_HIGH) && tick_i && (bit_q == 5'(FRAME_BITS));
    assign last_frame  = burst_q ? (frame_q == FRM_W'(N_WORDS)) : (frame_q == FRM_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_burst || start_read) state_d = ST_LEAD;
            ST_LEAD:  if (tick_i) state_d = ST_LOW;
            ST_LOW:   if (tick_i) state_d = ST_HIGH;
            ST_HIGH: begin
                if (tick_i) begin
                    if (bit_q != 5'(FRAME_BITS)) state_d = ST_LOW;
                    else if (last_frame)         state_d = ST_IDLE;
                    else if (burst_q)            state_d = ST_GAP;
                    else                         state_d = ST_CSOFF;
                end
            end
            ST_GAP:   if (tick_i && half2_q) state_d = ST_LOW;
            ST_CSOFF: if (tick_i && half2_q) state_d = ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control outputs from the state
    always_comb begin
        cs_n_o      = (state_q == ST_IDLE) || (state_q == ST_CSOFF);
        sclk_o      = (state_q != ST_LOW);
        busy_o      = (state_q != ST_IDLE);
        tmr_run_o   = busy_o;
        tmr_load_o  = start_burst || start_read;
        tmr_burst_o = start_burst;
        sh_sample_o = (state_q == ST_LOW) && tick_i;
        sh_shift_o  = (state_q == ST_HIGH) && tick_i && (bit_q != 5'(FRAME_BITS));
        sh_load_o   = start_burst || start_read || frame_end;
        if (start_burst)     sh_word_o = BURST_CMD;
        else if (start_read) sh_word_o = {1'b0, rd_addr_i, {PAD_W{1'b0}}};
        else                 sh_word_o = 16'h0000;
    end

    // sequencing counters and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q   <= 1'b0;
            frame_q   <= '0;
            bit_q     <= '0;
            half2_q   <= 1'b0;
            drdy_q    <= 1'b0;
            overrun_q <= 1'b0;
            wv_q      <= 1'b0;
            rv_q      <= 1'b0;
            widx_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
        end else begin
            drdy_q <= drdy_i;
            wv_q   <= 1'b0;
            rv_q   <= 1'b0;
            if (drdy_edge && (state_q != ST_IDLE)) overrun_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    frame_q <= '0;
                    bit_q   <= '0;
                    half2_q <= 1'b0;
                    if (start_burst)     burst_q <= 1'b1;
                    else if (start_read) burst_q <= 1'b0;
                end
                ST_LOW: if (tick_i) bit_q <= bit_q + 5'd1;
                ST_HIGH: begin
                    if (frame_end) begin
                        bit_q   <= '0;
                        frame_q <= frame_q + FRM_W'(1);
                        if (burst_q && (frame_q != '0)) begin
                            wv_q    <= 1'b1;
                            widx_q  <= IDX_W'(frame_q - FRM_W'(1));
                            wdata_q <= rx_word_i;
                        end
                        if (!burst_q && (frame_q == FRM_W'(1))) begin
                            rv_q    <= 1'b1;
                            rdata_q <= rx_word_i;
                        end
                    end
                end
                ST_GAP, ST_CSOFF: if (tick_i) half2_q <= !half2_q;
                default: ;
            endcase
        end
    end

    assign word_valid_o = wv_q;
    assign word_idx_o   = widx_q;
    assign word_data_o  = wdata_q;
    assign rd_valid_o   = rv_q;
    assign rd_data_o    = rdata_q;
    assign overrun_o    = overrun_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wv_q |=> !wv_q) // R3
        else $error("word strobe longer than one cycle");
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wv_q |-> (32'(widx_q) < N_WORDS)) // R3
        else $error("word index out of range");
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |=> overrun_q) // R9
        else $error("overrun flag cleared");
endmodule

// File: rtl/burst_spi_collector.sv
module burst_spi_collector #(
    parameter int N_WORDS        = 12,
    parameter int DIV_W          = 8,
    parameter int MIN_BURST_HALF = 50,
    localparam int IDX_W         = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drdy_i,
    input  logic             rd_req_i,
    input  logic [6:0]       rd_addr_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic             miso_i,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             word_valid_o,
    output logic [IDX_W-1:0] word_idx_o,
    output logic [15:0]      word_data_o,
    output logic             rd_valid_o,
    output logic [15:0]      rd_data_o,
    output logic             overrun_o
);
    logic        tick;
    logic        tmr_load, tmr_burst, tmr_run;
    logic        sh_load, sh_shift, sh_sample;
    logic [15:0] sh_word, rx_word;

    bsc_halfclk #(
        .DIV_W         (DIV_W),
        .MIN_BURST_HALF(MIN_BURST_HALF)
    ) u_halfclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .burst_sel(tmr_burst),
        .run      (tmr_run),
        .half_div (half_div_i),
        .tick     (tick)
    );

    bsc_shreg #(.W(16)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_word(sh_word),
        .shift    (sh_shift),
        .sample   (sh_sample),
        .miso     (miso_i),
        .mosi     (mosi_o),
        .rx_word  (rx_word)
    );

    bsc_fsm #(
        .N_WORDS(N_WORDS),
        .ADDR_W (7),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .drdy_i      (drdy_i),
        .rd_req_i    (rd_req_i),
        .rd_addr_i   (rd_addr_i),
        .tick_i      (tick),
        .rx_word_i   (rx_word),
        .tmr_load_o  (tmr_load),
        .tmr_burst_o (tmr_burst),
        .tmr_run_o   (tmr_run),
        .sh_load_o   (sh_load),
        .sh_word_o   (sh_word),
        .sh_shift_o  (sh_shift),
        .sh_sample_o (sh_sample),
        .sclk_o      (sclk_o),
        .cs_n_o      (cs_n_o),
        .busy_o      (busy_o),
        .word_valid_o(word_valid_o),
        .word_idx_o  (word_idx_o),
        .word_data_o (word_data_o),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .overrun_o   (overrun_o)
    );

    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o) // R2
        else $error("clock low with chip select released");
    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o) // R11
        else $error("chip select asserted while not busy");
endmodule

// File: tb/burst_spi_collector_tb.sv
module burst_spi_collector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 12;
    localparam int MINH       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drdy = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  half_div = 8'd0;
    logic        miso = 1'b1;
    logic        sclk, cs_n, mosi, busy, wvalid, rvalid, overrun;
    logic [3:0]  widx;
    logic [15:0] wdata, rdata;

    burst_spi_collector #(
        .N_WORDS(NW), .DIV_W(8), .MIN_BURST_HALF(MINH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .drdy_i(drdy), .rd_req_i(rd_req),
        .rd_addr_i(rd_addr), .half_div_i(half_div), .miso_i(miso),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .busy_o(busy),
        .word_valid_o(wvalid), .word_idx_o(widx), .word_data_o(wdata),
        .rd_valid_o(rvalid), .rd_data_o(rdata), .overrun_o(overrun)
    );

    initial forever #(CLK_PERIOD / 2) clk = !clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [15:0] burst_word(input logic [15:0] s, input int k);
        return {s[7:0], s[15:8]} ^ 16'(k * 16'h0917 + 3);
    endfunction

    function automatic logic [15:0] reg_val(input logic [6:0] a);
        return {~a, 2'b10, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // behavioural sensor model and timing monitor
    longint      t_csfall, t_fall, t_rise;
    int          bitpos, fidx, nframes, lead_cyc, trail_cyc;
    int          half_min, half_max, gap_min, gap_max;
    logic [15:0] cur_tx, rx_sh;
    logic [15:0] mosi_log [0:63];
    bit          bmode, pend;
    logic [6:0]  pend_addr;
    logic [15:0] bseed;

    always @(negedge cs_n) begin
        t_csfall = $time;
        bitpos = 0;
        fidx = 0;
        bmode = 0;
    end

    always @(negedge sclk) if (!cs_n) begin
        int d;
        if (bitpos == 0) begin
            if (fidx == 0) lead_cyc = int'(($time - t_csfall) / CLK_PERIOD);
            else begin
                d = int'(($time - t_rise) / CLK_PERIOD);
                if (d < gap_min) gap_min = d;
                if (d > gap_max) gap_max = d;
            end
            if (bmode && fidx > 0) cur_tx = burst_word(bseed, fidx - 1);
            else if (pend) begin
                cur_tx = reg_val(pend_addr);
                pend = 0;
            end else cur_tx = 16'hC35A;
        end else begin
            d = int'(($time - t_rise) / CLK_PERIOD);
            if (d < half_min) half_min = d;
            if (d > half_max) half_max = d;
        end
        miso = cur_tx[15 - bitpos];
        t_fall = $time;
    end

    always @(posedge sclk) if (!cs_n) begin
        int d;
        d = int'(($time - t_fall) / CLK_PERIOD);
        if (d < half_min) half_min = d;
        if (d > half_max) half_max = d;
        rx_sh = {rx_sh[14:0], mosi};
        bitpos++;
        t_rise = $time;
        if (bitpos == 16) begin
            if (nframes < 64) mosi_log[nframes] = rx_sh;
            nframes++;
            if (fidx == 0 && rx_sh == 16'h3E00) bmode = 1;
            else if (fidx == 0 && !rx_sh[15] && rx_sh != 16'h0000) begin
                pend = 1;
                pend_addr = rx_sh[14:8];
            end
            fidx++;
            bitpos = 0;
        end
    end

    always @(posedge cs_n) trail_cyc = int'(($time - t_rise) / CLK_PERIOD);

    // output collector
    logic [15:0] got_d [0:63];
    int          got_i [0:63];
    int          nw, nrd;
    logic [15:0] rd_got;

    always @(negedge clk) begin
        if (rst_n && wvalid) begin
            if (nw < 64) begin
                got_d[nw] = wdata;
                got_i[nw] = int'(widx);
            end
            nw++;
        end
        if (rst_n && rvalid) begin
            rd_got = rdata;
            nrd++;
        end
    end

    task automatic clear_meas();
        nframes = 0; nw = 0; nrd = 0;
        half_min = 1000000; half_max = 0;
        gap_min = 1000000; gap_max = 0;
        lead_cyc = -1; trail_cyc = -1;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!busy && n < 10) begin
            @(negedge clk);
            n++;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_drdy();
        @(negedge clk) drdy = 1'b1;
        @(negedge clk) drdy = 1'b0;
    endtask

    task automatic check_burst(input int exp_half, input string tag);
        chk(nframes == NW + 1, "R3", {tag, " frame count"}, nframes, NW + 1);
        chk(mosi_log[0] == 16'h3E00, "R2", {tag, " command word"}, mosi_log[0], 16'h3E00);
        for (int k = 1; k <= NW; k++)
            chk(mosi_log[k] == 16'h0000, "R3", {tag, " follow-on mosi"}, mosi_log[k], 0);
        chk(nw == NW, "R3", {tag, " word count"}, nw, NW);
        for (int k = 0; k < NW; k++) begin
            chk(got_i[k] == k, "R3", {tag, " word index"}, got_i[k], k);
            chk(got_d[k] == burst_word(bseed, k), "R3", {tag, " word data"},
                got_d[k], burst_word(bseed, k));
        end
        chk(half_min == exp_half && half_max == exp_half, "R4", {tag, " half-period"},
            (half_max << 16) | half_min, (exp_half << 16) | exp_half);
        chk(gap_min == 3 * exp_half && gap_max == 3 * exp_half, "R6", {tag, " word gap"},
            (gap_max << 16) | gap_min, (3 * exp_half << 16) | 3 * exp_half);
        chk(lead_cyc == exp_half, "R7", {tag, " cs lead"}, lead_cyc, exp_half);
        chk(trail_cyc == exp_half, "R7", {tag, " cs trail"}, trail_cyc, exp_half);
        chk(!busy && cs_n && sclk, "R11", {tag, " idle after"}, {busy, cs_n, sclk}, 3'b011);
    endtask

    task automatic run_burst(input logic [7:0] hd, input int exp_half, input string tag);
        clear_meas();
        bseed = 16'($urandom);
        half_div = hd;
        pulse_drdy();
        wait_done();
        check_burst(exp_half, tag);
    endtask

    task automatic run_read(input logic [6:0] a, input logic [7:0] hd);
        int exp_half;
        exp_half = (hd == 0) ? 1 : int'(hd);
        clear_meas();
        half_div = hd;
        @(negedge clk) begin rd_req = 1'b1; rd_addr = a; end
        @(negedge clk) rd_req = 1'b0;
        wait_done();
        chk(nframes == 2, "R8", "read frame count", nframes, 2);
        chk(mosi_log[0] == {1'b0, a, 8'h00}, "R8", "read address frame",
            mosi_log[0], {1'b0, a, 8'h00});
        chk(mosi_log[1] == 16'h0000, "R8", "read data frame mosi", mosi_log[1], 0);
        chk(nrd == 1 && rd_got == reg_val(a), "R8", "read result", rd_got, reg_val(a));
        chk(nw == 0, "R8", "no burst words on read", nw, 0);
        chk(half_min == exp_half && half_max == exp_half, "R5", "read half-period",
            (half_max << 16) | half_min, (exp_half << 16) | exp_half);
    endtask

    initial begin
        void'($urandom(32'd4242));
        clear_meas();
        pend = 0;
        rx_sh = '0;
        repeat (4) @(negedge clk);
        chk(cs_n && sclk && !busy && !wvalid && !rvalid && !overrun, "R1", "reset state",
            {cs_n, sclk, busy, wvalid, rvalid, overrun}, 6'b110000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !busy && !overrun, "R1", "after reset release",
            {cs_n, sclk, busy, overrun}, 4'b1100);

        // R4 floor clamp, then a rate above the floor
        run_burst(8'd2, MINH, "burst clamped");
        begin
            logic [7:0] hd;
            hd = 8'($urandom_range(MINH + 1, MINH + 6));
            run_burst(hd, int'(hd), "burst slow");
        end

        // R5 R8 random reads, plus the zero-divider corner
        for (int i = 0; i < 4; i++) begin
            logic [6:0] a;
            do a = 7'($urandom_range(1, 127)); while (a == 7'h3E);
            run_read(a, 8'($urandom_range(1, 9)));
        end
        run_read(7'h21, 8'd0);

        // R9 R10 overrun and ignored read while busy
        chk(overrun == 1'b0, "R9", "no overrun yet", overrun, 0);
        clear_meas();
        bseed = 16'($urandom);
        half_div = 8'd0;
        pulse_drdy();
        repeat (300) @(negedge clk);
        chk(busy && !cs_n, "R11", "busy mid-burst", {busy, cs_n}, 2'b10);
        pulse_drdy();
        @(negedge clk) begin rd_req = 1'b1; rd_addr = 7'h10; end
        @(negedge clk) rd_req = 1'b0;
        wait_done();
        chk(overrun == 1'b1, "R9", "overrun set", overrun, 1);
        chk(nw == NW && nframes == NW + 1, "R9", "burst unchanged by extra pulse", nw, NW);
        chk(nrd == 0, "R10", "read while busy ignored", nrd, 0);
        repeat (20) @(negedge clk);
        chk(!busy && cs_n, "R9", "no extra transfer", {busy, cs_n}, 2'b01);
        run_burst(8'd3, MINH, "burst after overrun");
        chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);

        // R10 simultaneous start
        clear_meas();
        bseed = 16'($urandom);
        @(negedge clk) begin drdy = 1'b1; rd_req = 1'b1; rd_addr = 7'h05; end
        @(negedge clk) begin drdy = 1'b0; rd_req = 1'b0; end
        wait_done();
        chk(mosi_log[0] == 16'h3E00 && nframes == NW + 1, "R10", "burst wins",
            mosi_log[0], 16'h3E00);
        chk(nrd == 0 && nw == NW, "R10", "read dropped", nrd, 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule